// File: doc/BRIEF.md
# First-Hit Encoded TDC Readout Formatter

This block turns one trigger's worth of time-to-digital converter data into a record whose length never depends on occupancy. There are 32 single-hit channels. Each channel may have a hit in up to three consecutive bunch crossings, and each crossing carries a 6-bit drift time per channel. For every channel the formatter keeps only the earliest hit among the crossings that the crossing-count setting enables. It then packs that hit into an 8-bit entry: a 2-bit crossing code and the drift time.

An accepted trigger captures the 32-bit header and all 32 channel entries in a single clock edge. The record is then streamed out as 36 bytes on consecutive cycles. A valid strobe marks every byte and a last flag marks the final one. Because the length is fixed, the readout time is always 36 cycles, which keeps every converter in the system in step. A trigger that arrives while a record is still streaming is dropped. It also sets a sticky overflow flag, which stays high until reset.

The controller has three named states:
- `ST_IDLE` waits for a trigger. On a trigger it loads the record buffer and moves to `ST_HEAD`.
- `ST_HEAD` streams the header bytes. After the last header byte it moves to `ST_BODY`.
- `ST_BODY` streams the channel entries. After entry 31 it returns to `ST_IDLE`.

Top module: `tdc_fh_formatter`

## Requirements
- R1: A record is 36 bytes. Byte i carries record bits 8i+7..8i. Bytes 0 to 3 are the header, least significant byte first.
- R2: Byte 4+k is the entry for channel k. Bits 7:6 hold the crossing code and bits 5:0 hold the drift time of that crossing for that channel.
- R3: The crossing code is 00, 01 or 10 when the earliest enabled hit is in crossing 1, 2 or 3. That crossing's drift time is reported, and later hits in the same channel are discarded.
- R4: A channel with no enabled hit yields code 11 with drift bits zero, so the entry is 0xC0.
- R5: Only crossings 1..N count, where N is the crossing-count input (values 1, 2 or 3; the value 0 is treated as 1). Hits in crossings above N have no effect.
- R6: Byte 0 is presented the cycle after the edge that accepts the trigger. Valid stays high for 36 consecutive cycles, last is high only on byte 35, and valid is low on the cycle after that.
- R7: A trigger sampled while a record is streaming is ignored, so the current record continues unchanged. It sets the overflow output, which stays high until reset.
- R8: Header, hitmask and drift inputs are sampled only at the accepted trigger edge. Changes to them during streaming do not alter the record.
- R9: After reset, valid, last and overflow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Trigger strobe, one cycle |
| header_i | input | 32 | Record header |
| bx_cnt_i | input | 2 | Number of crossings searched (0 treated as 1) |
| hitmask_i | input | 96 | Hit bit for crossing b, channel c at b*32+c |
| drift_i | input | 576 | Drift time for crossing b, channel c at (b*32+c)*6 |
| byte_o | output | 8 | Record byte |
| valid_o | output | 1 | Byte valid |
| last_o | output | 1 | Final byte of record |
| overflow_o | output | 1 | Sticky flag: trigger was lost during readout |

## Verification
The bench builds the block with its default parameters: 32 channels, 6-bit drift times and three crossings. At these values every crossing code and the 0xC0 empty entry can occur within one record.

Random hitmasks are drawn at low, middle and full occupancy. Together with the crossing counts 0 through 3, they exercise first-hit selection where later hits compete with earlier ones and where disabled crossings hold hits. Directed records place hits only in crossings above the programmed count. A trigger is injected in the middle of a record. Inputs are scrambled during streaming to show that the captured record is held.

// File: rtl/tdc_fh_pkg.sv
package tdc_fh_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_BODY = 2'd2
    } rd_state_e;

    localparam logic [1:0] POS_NONE = 2'b11;
endpackage

// File: rtl/tdc_fh_encoder.sv
module tdc_fh_encoder #(
    parameter int NUM_CH = 32,
    parameter int DT_W   = 6,
    parameter int MAX_BX = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    bx_cnt_i,
    input  logic [MAX_BX*NUM_CH-1:0]      hitmask_i,
    input  logic [MAX_BX*NUM_CH*DT_W-1:0] drift_i,
    output logic [NUM_CH*(DT_W+2)-1:0]    entries_o
);
    import tdc_fh_pkg::*;

    localparam int ENT_W = DT_W + 2;

    int eff_n;
    always_comb begin
        eff_n = (bx_cnt_i == 2'd0) ? 1 : int'(bx_cnt_i);
        if (eff_n > MAX_BX) eff_n = MAX_BX;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [1:0]      pos;
        logic [DT_W-1:0] dt;

        // scan from the latest crossing down so the earliest enabled hit wins
        always_comb begin
            pos = POS_NONE;
            dt  = '0;
            for (int b = MAX_BX - 1; b >= 0; b--) begin
                if (b < eff_n && hitmask_i[b*NUM_CH + ch]) begin
                    pos = 2'(b);
                    dt  = drift_i[(b*NUM_CH + ch)*DT_W +: DT_W];
                end
            end
        end

        assign entries_o[ch*ENT_W +: ENT_W] = {pos, dt};

        AST_CODE_WITHIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
            (pos == 2'b10) |-> (bx_cnt_i == 2'd3)); // R5
        AST_NOHIT_MEANS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
            (pos == POS_NONE) |-> !hitmask_i[ch]); // R4
        AST_FIRST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            hitmask_i[ch] |-> (pos == 2'b00)); // R3
    end
endmodule

// File: rtl/tdc_rec_buffer.sv
module tdc_rec_buffer #(
    parameter int HDR_W  = 32,
    parameter int NUM_CH = 32,
    parameter int ENT_W  = 8,
    parameter int IDX_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [HDR_W-1:0]        header_i,
    input  logic [NUM_CH*ENT_W-1:0] entries_i,
    input  logic [IDX_W-1:0]        sel_i,
    output logic [ENT_W-1:0]        word_o
);
    localparam int REC_W  = HDR_W + NUM_CH*ENT_W;
    localparam int NWORDS = REC_W / ENT_W;

    logic [REC_W-1:0] rec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rec_q <= '0;
        else if (load_i) rec_q <= {entries_i, header_i};
    end

    always_comb begin
        word_o = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (sel_i == IDX_W'(w)) word_o = rec_q[w*ENT_W +: ENT_W];
        end
    end

    AST_REC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(rec_q)); // R8
endmodule

// File: rtl/tdc_readout_fsm.sv
module tdc_readout_fsm #(
    parameter int HDR_WORDS = 4,
    parameter int NWORDS    = 36,
    parameter int IDX_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    output logic             load_o,
    output logic [IDX_W-1:0] sel_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             overflow_o
);
    import tdc_fh_pkg::*;

    rd_state_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             ovf_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= (state_q == ST_IDLE) ? '0 : idx_q + 1'b1;
            if (trig_i && state_q != ST_IDLE) ovf_q <= 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (trig_i) state_d = ST_HEAD;
            ST_HEAD: if (idx_q == IDX_W'(HDR_WORDS-1)) state_d = ST_BODY;
            ST_BODY: if (idx_q == IDX_W'(NWORDS-1)) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o  = 1'b0;
        valid_o = 1'b0;
        last_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = trig_i;
            ST_HEAD: valid_o = 1'b1;
            ST_BODY: begin
                valid_o = 1'b1;
                last_o  = (idx_q == IDX_W'(NWORDS-1));
            end
            default: ;
        endcase
    end

    assign sel_o      = idx_q;
    assign overflow_o = ovf_q;

    AST_LAST_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o); // R6
    AST_RUN_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> valid_o); // R6
    AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !valid_o); // R6
    AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && valid_o) |=> overflow_o); // R7
    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o); // R7
    AST_HEAD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HEAD) |-> (idx_q < IDX_W'(HDR_WORDS))); // R1
endmodule

// File: rtl/tdc_fh_formatter.sv
module tdc_fh_formatter #(
    parameter int NUM_CH = 32,
    parameter int DT_W   = 6,
    parameter int MAX_BX = 3,
    parameter int HDR_W  = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          trig_i,
    input  logic [HDR_W-1:0]              header_i,
    input  logic [1:0]                    bx_cnt_i,
    input  logic [MAX_BX*NUM_CH-1:0]      hitmask_i,
    input  logic [MAX_BX*NUM_CH*DT_W-1:0] drift_i,
    output logic [DT_W+1:0]               byte_o,
    output logic                          valid_o,
    output logic                          last_o,
    output logic                          overflow_o
);
    localparam int ENT_W     = DT_W + 2;
    localparam int REC_W     = HDR_W + NUM_CH*ENT_W;
    localparam int NWORDS    = REC_W / ENT_W;
    localparam int HDR_WORDS = HDR_W / ENT_W;
    localparam int IDX_W     = $clog2(NWORDS + 1);

    logic [NUM_CH*ENT_W-1:0] entries;
    logic                    load;
    logic [IDX_W-1:0]        sel;

    tdc_fh_encoder #(.NUM_CH(NUM_CH), .DT_W(DT_W), .MAX_BX(MAX_BX)) u_enc (
        .clk(clk), .rst_n(rst_n), .bx_cnt_i(bx_cnt_i),
        .hitmask_i(hitmask_i), .drift_i(drift_i), .entries_o(entries)
    );

    tdc_rec_buffer #(.HDR_W(HDR_W), .NUM_CH(NUM_CH), .ENT_W(ENT_W), .IDX_W(IDX_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .load_i(load), .header_i(header_i),
        .entries_i(entries), .sel_i(sel), .word_o(byte_o)
    );

    tdc_readout_fsm #(.HDR_WORDS(HDR_WORDS), .NWORDS(NWORDS), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .load_o(load), .sel_o(sel),
        .valid_o(valid_o), .last_o(last_o), .overflow_o(overflow_o)
    );
endmodule

// File: tb/tdc_fh_formatter_tb_top.sv
module tdc_fh_formatter_tb_top;
    localparam int NCH = 32;
    localparam int DTW = 6;
    localparam int NBX = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig = 1'b0;
    logic [31:0] hdr = '0;
    logic [1:0]  bxc = 2'd3;
    logic [NBX*NCH-1:0]     hm = '0;
    logic [NBX*NCH*DTW-1:0] dr = '0;
    logic [7:0] byte_o;
    logic valid_o, last_o, overflow_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tdc_fh_formatter dut_i (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .header_i(hdr), .bx_cnt_i(bxc),
        .hitmask_i(hm), .drift_i(dr), .byte_o(byte_o), .valid_o(valid_o),
        .last_o(last_o), .overflow_o(overflow_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [287:0] exp_rec(input logic [31:0] h, input logic [NBX*NCH-1:0] m,
                                             input logic [NBX*NCH*DTW-1:0] d, input logic [1:0] c);
        logic [287:0] r;
        int n;
        n = (c == 2'd0) ? 1 : int'(c);
        r = '0;
        r[31:0] = h;
        for (int ch = 0; ch < NCH; ch++) begin
            logic [1:0] p;
            logic [5:0] t;
            p = 2'b11;
            t = '0;
            for (int b = 0; b < NBX; b++) begin
                if (p == 2'b11 && b < n && m[b*NCH+ch]) begin
                    p = 2'(b);
                    t = d[(b*NCH+ch)*DTW +: DTW];
                end
            end
            r[32+8*ch +: 8] = {p, t};
        end
        return r;
    endfunction

    task automatic rnd_inputs(input int pct);
        hdr = $urandom;
        for (int i = 0; i < NBX*NCH; i++) hm[i] = (($urandom % 100) < pct);
        for (int i = 0; i < NBX*NCH*DTW; i++) dr[i] = $urandom % 2;
    endtask

    // Drive trigger at negedge, stream 36 bytes and check each.
    task automatic run_rec(input logic [1:0] c, input int inject_at);
        logic [287:0] e;
        bxc = c;
        e = exp_rec(hdr, hm, dr, c);
        trig = 1'b1;
        @(posedge clk);
        @(negedge clk);
        trig = 1'b0;
        rnd_inputs(50);            // R8: scramble after capture
        bxc = 2'($urandom % 4);
        for (int w = 0; w < 36; w++) begin
            chk("R6 valid", 32'(valid_o), 32'd1);
            chk(w < 4 ? "R1 header byte" : "R2/R3/R4/R5/R8 entry byte", 32'(byte_o), 32'(e[8*w +: 8]));
            chk("R6 last", 32'(last_o), (w == 35) ? 32'd1 : 32'd0);
            if (w == inject_at) trig = 1'b1;  // R7: trigger while streaming
            @(negedge clk);
            trig = 1'b0;
        end
        chk("R6 valid drops", 32'(valid_o), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R9 valid", 32'(valid_o), 32'd0);
        chk("R9 last", 32'(last_o), 32'd0);
        chk("R9 overflow", 32'(overflow_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: no hits at all
        hdr = 32'hA1B2C3D4; hm = '0; dr = '1;
        run_rec(2'd3, -1);
        // R3: every crossing hit, first crossing wins
        hdr = 32'h01234567; hm = '1; rnd_inputs(0); hm = '1;
        run_rec(2'd3, -1);
        // R5: hits only in crossing 3 with count 2
        rnd_inputs(0); hm[3*NCH-1:2*NCH] = '1;
        run_rec(2'd2, -1);
        // R5: hits only in crossing 2 with count 0 (treated as 1)
        rnd_inputs(0); hm[2*NCH-1:NCH] = '1;
        run_rec(2'd0, -1);
        // R3: crossings 2 and 3 hit, count 3 gives code 01
        rnd_inputs(0); hm[3*NCH-1:NCH] = '1;
        run_rec(2'd3, -1);
        chk("R7 no overflow yet", 32'(overflow_o), 32'd0);

        // R7: trigger injected mid-record
        rnd_inputs(30);
        run_rec(2'd3, 17);
        chk("R7 overflow set", 32'(overflow_o), 32'd1);

        for (int k = 0; k < 20; k++) begin
            int pct;
            pct = (k % 4 == 0) ? 5 : (k % 4 == 1) ? 40 : (k % 4 == 2) ? 80 : 100;
            rnd_inputs(pct);
            run_rec(2'($urandom % 4), -1);
            repeat ($urandom % 3) @(negedge clk);
        end
        chk("R7 overflow sticky", 32'(overflow_o), 32'd1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule